// File: doc/BRIEF.md
# Dual-Role SPI Serial Port

This block is an 8-bit synchronous serial port that acts as either the clock-driving end (master) or the clock-following end (slave) of an SPI link. A 4-bit mode field picks the role, the source of the serial clock when mastering, and whether a slave honours its select input. Software reaches the port through a small register interface: a control register, a data register, a clock divider register and a read-only status register. The port keeps the received byte in a buffer register and does the shifting in a separate internal shift register.

In master mode, writing the data register starts an exchange of one byte. In slave mode, the same write only preloads the byte that goes out on the next exchange, which the remote master then clocks. Two sticky error flags record misuse. A write collision flag is set by a data write while a byte is still shifting. A receive overflow flag is set when a slave completes a byte while the previous one has not been read. Software clears either flag by writing 0 to its control bit.

Register map: address 0 is control, 1 is data, 2 is the divider, 3 is status. Control bits: [0] enable, [1] clock idle level, [5:2] mode code, [6] write collision, [7] receive overflow. Status bits: [0] buffer full, [1] shifting in progress, [7:2] read 0.

Top module: `spi_dual_port`

## Requirements
- R1: After reset, the control, status and data registers read 0, and both output enables (`sck_oe`, `sdo_oe`) are 0.
- R2: Mode codes 0000, 0001 and 0010 make the port a master whose SCK edges are 2, 8 and 32 clock cycles apart, which gives SCK at clock/4, /16 and /64. A byte is exchanged MSB first as 16 SCK edges. SDI is sampled on each leading (away-from-idle) edge, and SDO changes only on trailing edges.
- R3: Mode code 0011 makes the port a master whose SCK toggles once per `tmr_match` pulse, so SCK runs at half the pulse rate.
- R4: Mode code 1010 makes the port a master whose SCK edges are 2·(D+1) cycles apart, where D is the divider register. D = 0 is not a supported setting.
- R5: Control bit 1 sets the SCK idle level: 1 means idle high, 0 means idle low. A master drives that level on `sck_o` while it is not shifting.
- R6: Mode code 0100 makes the port a slave that ignores SCK and releases SDO while `ss_i` is high. Mode code 0101 makes it a slave that ignores `ss_i`. A slave never drives SCK.
- R7: A completed byte moves into the buffer and sets status bit 0. A read of the data address clears status bit 0.
- R8: A slave that completes a byte while status bit 0 is still set sets control bit 7. The new byte is dropped and the buffer keeps the older byte.
- R9: A master never sets control bit 7. A new byte overwrites the buffer.
- R10: A data write while a byte is shifting sets control bit 6. The write has no effect on the byte in flight.
- R11: Control bits 6 and 7 are cleared only by a control write with that bit at 0. Writing 1 to them leaves them unchanged.
- R12: With control bit 0 at 0, or with any mode code other than 0000–0101 and 1010, the port is idle. Both output enables are 0, and data writes start nothing and set no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write address |
| reg_wr_data | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (side effect on the data address only) |
| reg_rd_addr | input | 2 | Read address |
| reg_rd_data | output | 8 | Read data (combinational) |
| tmr_match | input | 1 | Timer match pulse, used as a clock source by mode 0011 |
| sck_i | input | 1 | Serial clock from a remote master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | SCK output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | SDO output enable |
| ss_i | input | 1 | Slave select, active low |

## Verification
The hardest state to reach is a slave overflow. It needs two complete slave exchanges with no read in between, each clocked by an external master that respects the port's synchronizer delay. The bench plays that master itself, with a fixed SCK half period and SDI changes placed after each trailing edge, and then checks the buffer, the flag and the loss rule. A write collision needs a data write landing inside the shifting window. The bench issues one at a fixed cycle offset into a slow /64 master transfer and then confirms that the byte on SDO is still the original. Random master and slave exchanges with random clock idle levels, modes and divider values cover the clocking relations.

// File: rtl/spi_dual_pkg.sv
package spi_dual_pkg;

    localparam int unsigned XW     = 8;
    localparam int unsigned DIV_W  = 8;
    localparam int unsigned HALF_W = DIV_W + 2;
    localparam int unsigned BIT_W  = $clog2(XW);

    typedef enum logic [1:0] {ROLE_OFF, ROLE_MASTER, ROLE_SLAVE} role_e;
    typedef enum logic [2:0] {SRC_Q4, SRC_Q16, SRC_Q64, SRC_TMR, SRC_PROG} sck_src_e;

    typedef struct packed {
        role_e    role;
        logic     ss_gated;
        sck_src_e src;
    } mode_cfg_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_DIV  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int CB_EN   = 0;
    localparam int CB_CPOL = 1;
    localparam int CB_MLO  = 2;
    localparam int CB_WCOL = 6;
    localparam int CB_OVF  = 7;

    function automatic mode_cfg_t decode_mode(input logic [3:0] code);
        mode_cfg_t c;
        c.role     = ROLE_OFF;
        c.ss_gated = 1'b0;
        c.src      = SRC_Q4;
        case (code)
            4'b0000: c.role = ROLE_MASTER;
            4'b0001: begin c.role = ROLE_MASTER; c.src = SRC_Q16;  end
            4'b0010: begin c.role = ROLE_MASTER; c.src = SRC_Q64;  end
            4'b0011: begin c.role = ROLE_MASTER; c.src = SRC_TMR;  end
            4'b1010: begin c.role = ROLE_MASTER; c.src = SRC_PROG; end
            4'b0100: begin c.role = ROLE_SLAVE;  c.ss_gated = 1'b1; end
            4'b0101: c.role = ROLE_SLAVE;
            default: c.role = ROLE_OFF;
        endcase
        return c;
    endfunction

    // Clock cycles between successive SCK edges for the counter-based sources
    function automatic logic [HALF_W-1:0] half_period(input sck_src_e s,
                                                      input logic [DIV_W-1:0] d);
        logic [HALF_W-1:0] h;
        case (s)
            SRC_Q16:  h = HALF_W'(8);
            SRC_Q64:  h = HALF_W'(32);
            SRC_PROG: h = ({2'b00, d} + HALF_W'(1)) << 1;
            default:  h = HALF_W'(2);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spi_bit_sync.sv
module spi_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= {st_q[STAGES-2:0], d};
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_sck_timer.sv
module spi_sck_timer
    import spi_dual_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  sck_src_e         src,
    input  logic [DIV_W-1:0] div_add,
    input  logic             tmr_match,
    output logic             tick
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half;
    logic              wrap;

    assign half = half_period(src, div_add);
    assign wrap = (cnt_q >= half - HALF_W'(1));

    always_comb begin
        if (!run)                tick = 1'b0;
        else if (src == SRC_TMR) tick = tmr_match;
        else                     tick = wrap;
    end

    always_ff @(posedge clk) begin
        if (rst || !run || src == SRC_TMR) cnt_q <= '0;
        else if (wrap)                     cnt_q <= '0;
        else                               cnt_q <= cnt_q + HALF_W'(1);
    end

    // R4: with a steady divider the counter never passes the half period
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && src != SRC_TMR && $stable(div_add) && $stable(src))
            |-> cnt_q < half);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_dual_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  role_e         role,
    input  logic          ss_gated,
    input  logic          cpol,
    input  logic          tick,
    input  logic          load,
    input  logic [XW-1:0] load_data,
    input  logic          sdi_raw,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic          ss_s,
    output logic          busy,
    output logic          done,
    output logic [XW-1:0] rx_data,
    output logic          sck_out,
    output logic          sdo_out,
    output logic          ss_block
);
    logic [XW-1:0]    sr_q;
    logic [BIT_W-1:0] cnt_q;
    logic             din_q, phase_q, busy_q, done_q, sck_prev_q;
    logic             sck_chg, lead_s, trail_s, last_bit;

    assign ss_block = ss_gated && ss_s;
    assign sck_chg  = sck_s ^ sck_prev_q;
    assign lead_s   = sck_chg && (sck_s != cpol);
    assign trail_s  = sck_chg && (sck_s == cpol);
    assign last_bit = (cnt_q == BIT_W'(XW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q       <= '0;
            cnt_q      <= '0;
            din_q      <= 1'b0;
            phase_q    <= 1'b0;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            sck_prev_q <= 1'b0;
        end else begin
            done_q     <= 1'b0;
            sck_prev_q <= sck_s;
            if (role == ROLE_OFF) begin
                busy_q  <= 1'b0;
                phase_q <= 1'b0;
                cnt_q   <= '0;
            end else if (load && !busy_q) begin
                sr_q    <= load_data;
                cnt_q   <= '0;
                phase_q <= 1'b0;
                busy_q  <= (role == ROLE_MASTER);
            end else if (role == ROLE_MASTER) begin
                if (busy_q && tick) begin
                    if (!phase_q) begin
                        phase_q <= 1'b1;
                        din_q   <= sdi_raw;
                    end else begin
                        phase_q <= 1'b0;
                        sr_q    <= {sr_q[XW-2:0], din_q};
                        cnt_q   <= cnt_q + BIT_W'(1);
                        if (last_bit) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end
            end else begin
                phase_q <= 1'b0;
                if (ss_block) begin
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                end else if (lead_s) begin
                    din_q  <= sdi_s;
                    busy_q <= 1'b1;
                end else if (trail_s && busy_q) begin
                    sr_q  <= {sr_q[XW-2:0], din_q};
                    cnt_q <= cnt_q + BIT_W'(1);
                    if (last_bit) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_data = sr_q;
    assign sck_out = cpol ^ phase_q;
    assign sdo_out = sr_q[XW-1];

    // R5: an idle master sits at the idle clock level
    a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_MASTER && !busy_q) |-> !phase_q);
    // R2: a byte completes only after the full bit count
    a_r2_full_byte: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cnt_q == '0 && !busy_q));
    // R6: a deselected gated slave holds no transfer
    a_r6_ss_hold: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_SLAVE && ss_block) |=> !busy_q);
    // R12: an idle port drops any transfer
    a_r12_off_idle: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_OFF) |=> !busy_q);
endmodule

// File: rtl/spi_dual_port.sv
module spi_dual_port
    import spi_dual_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_wr_addr,
    input  logic [7:0] reg_wr_data,
    input  logic       reg_rd,
    input  logic [1:0] reg_rd_addr,
    output logic [7:0] reg_rd_data,
    input  logic       tmr_match,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       sdi_i,
    output logic       sdo_o,
    output logic       sdo_oe,
    input  logic       ss_i
);
    localparam int NPIN = 3;

    logic          en_q, cpol_q, wcol_q, ovf_q, bf_q;
    logic [3:0]    mode_q;
    logic [XW-1:0]    buf_q;
    logic [DIV_W-1:0] div_q;

    mode_cfg_t cfg;
    role_e     role_eff;
    logic      ctrl_wr, data_wr, div_wr, rd_clr;
    logic      eng_busy, eng_done, eng_sck, eng_sdo, ss_block, tick;
    logic      collide, load, slave_full, bf_eff;
    logic [XW-1:0]   eng_rx;
    logic [NPIN-1:0] pin_raw, pin_s;

    assign cfg      = decode_mode(mode_q);
    assign role_eff = en_q ? cfg.role : ROLE_OFF;

    assign ctrl_wr = reg_wr && reg_wr_addr == A_CTRL;
    assign data_wr = reg_wr && reg_wr_addr == A_DATA;
    assign div_wr  = reg_wr && reg_wr_addr == A_DIV;
    assign rd_clr  = reg_rd && reg_rd_addr == A_DATA;

    assign collide    = data_wr && role_eff != ROLE_OFF && eng_busy;
    assign load       = data_wr && role_eff != ROLE_OFF && !eng_busy;
    assign bf_eff     = bf_q && !rd_clr;
    assign slave_full = eng_done && role_eff == ROLE_SLAVE && bf_eff;

    assign pin_raw = {ss_i, sdi_i, sck_i};
    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        spi_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pin_raw[g]),
            .q   (pin_s[g])
        );
    end

    spi_sck_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (role_eff == ROLE_MASTER && eng_busy),
        .src       (cfg.src),
        .div_add   (div_q),
        .tmr_match (tmr_match),
        .tick      (tick)
    );

    spi_shift_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .role      (role_eff),
        .ss_gated  (cfg.ss_gated),
        .cpol      (cpol_q),
        .tick      (tick),
        .load      (load),
        .load_data (reg_wr_data),
        .sdi_raw   (sdi_i),
        .sck_s     (pin_s[0]),
        .sdi_s     (pin_s[1]),
        .ss_s      (pin_s[2]),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_data   (eng_rx),
        .sck_out   (eng_sck),
        .sdo_out   (eng_sdo),
        .ss_block  (ss_block)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            cpol_q <= 1'b0;
            mode_q <= '0;
            div_q  <= '0;
            wcol_q <= 1'b0;
            ovf_q  <= 1'b0;
            bf_q   <= 1'b0;
            buf_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q   <= reg_wr_data[CB_EN];
                cpol_q <= reg_wr_data[CB_CPOL];
                mode_q <= reg_wr_data[CB_MLO +: 4];
            end
            if (div_wr) div_q <= reg_wr_data;
            wcol_q <= collide    | (wcol_q & ~(ctrl_wr & ~reg_wr_data[CB_WCOL]));
            ovf_q  <= slave_full | (ovf_q  & ~(ctrl_wr & ~reg_wr_data[CB_OVF]));
            if (eng_done && !slave_full) begin
                buf_q <= eng_rx;
                bf_q  <= 1'b1;
            end else if (rd_clr) begin
                bf_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_rd_addr)
            A_CTRL:  reg_rd_data = {ovf_q, wcol_q, mode_q, cpol_q, en_q};
            A_DATA:  reg_rd_data = buf_q;
            A_DIV:   reg_rd_data = div_q;
            default: reg_rd_data = {6'b0, eng_busy, bf_q};
        endcase
    end

    assign sck_o  = eng_sck;
    assign sck_oe = (role_eff == ROLE_MASTER);
    assign sdo_o  = eng_sdo;
    assign sdo_oe = (role_eff == ROLE_MASTER) || (role_eff == ROLE_SLAVE && !ss_block);

    // R10: a write during shifting raises the collision flag
    a_r10_wcol_set: assert property (@(posedge clk) disable iff (rst)
        (data_wr && eng_busy && role_eff != ROLE_OFF) |=> wcol_q);
    // R9: master completions never raise overflow
    a_r9_no_master_ovf: assert property (@(posedge clk) disable iff (rst)
        (eng_done && role_eff == ROLE_MASTER) |=> !$rose(ovf_q));
    // R8: slave overrun keeps the old byte and flags it
    a_r8_keep_old: assert property (@(posedge clk) disable iff (rst)
        (eng_done && role_eff == ROLE_SLAVE && bf_q && !rd_clr) |=> (ovf_q && $stable(buf_q)));
    // R11: flags persist unless software writes 0
    a_r11_wcol_sticky: assert property (@(posedge clk) disable iff (rst)
        (wcol_q && !(ctrl_wr && !reg_wr_data[CB_WCOL])) |=> wcol_q);
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(ctrl_wr && !reg_wr_data[CB_OVF])) |=> ovf_q);
    // R7: reading the data address empties the buffer when nothing arrives
    a_r7_bf_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !eng_done) |=> !bf_q);
endmodule

// File: tb/tb_spi_dual_port.sv
module tb_spi_dual_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_wr_addr = 2'd0;
    logic [7:0] reg_wr_data = 8'd0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_rd_addr = 2'd0;
    logic [7:0] reg_rd_data;
    logic       tmr_match = 1'b0;
    logic       sck_i = 1'b0;
    logic       sck_o, sck_oe;
    logic       sdi_i = 1'b0;
    logic       sdo_o, sdo_oe;
    logic       ss_i = 1'b1;

    int vectors = 0;
    int miscompares = 0;

    localparam logic [1:0] AC = 2'd0, AD = 2'd1, AV = 2'd2, AS = 2'd3;

    spi_dual_port dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd(reg_rd), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .tmr_match(tmr_match),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .ss_i(ss_i)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // control word: flags written as 1 so they are preserved
    function automatic logic [7:0] cw(input bit en, input bit cpol, input logic [3:0] m);
        return {2'b11, m, cpol, en};
    endfunction

    function automatic int exp_half(input logic [3:0] m, input int d);
        case (m)
            4'b0001: return 8;
            4'b0010: return 32;
            4'b0011: return 5;
            4'b1010: return 2 * (d + 1);
            default: return 2;
        endcase
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_rd_addr = a;
        #1;
        v = reg_rd_data;
    endtask

    task automatic pop(output logic [7:0] v);
        @(negedge clk);
        reg_rd_addr = AD; reg_rd = 1'b1;
        #1;
        v = reg_rd_data;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Master exchange; the bench plays the remote slave
    task automatic master_xfer(input logic [3:0] m, input logic [7:0] d, input bit cpol,
                               input logic [7:0] tx, input logic [7:0] rxpat,
                               input int collide_at, input string tag);
        logic [7:0] cap = 8'd0, v;
        int since = 0, nedges = 0, bad_iv = 0, bitidx = 0, cyc = 0;
        int h = exp_half(m, int'(d));
        logic prev;
        wr(AV, d);
        wr(AC, cw(1'b1, cpol, m));
        sdi_i = rxpat[7];
        @(negedge clk);
        check(sck_o == cpol && sck_oe, {tag, " R5 idle level"}, {sck_oe, sck_o}, {1'b1, cpol});
        wr(AD, tx);
        prev = sck_o;
        reg_rd_addr = AS;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++; since++;
            if (m == 4'b0011) tmr_match = (cyc % 5 == 0);
            if (cyc == collide_at) begin
                reg_wr = 1'b1; reg_wr_addr = AD; reg_wr_data = ~tx;
            end else begin
                reg_wr = 1'b0;
            end
            if (sck_o !== prev) begin
                if (nedges > 0 && since != h) bad_iv++;
                nedges++; since = 0; prev = sck_o;
                if (sck_o != cpol) cap = {cap[6:0], sdo_o};
                else begin
                    bitidx++;
                    if (bitidx < 8) sdi_i = rxpat[7 - bitidx];
                end
            end
            #1;
            if (reg_rd_data[1] == 1'b0 && cyc > 1) break;
        end
        reg_wr = 1'b0; tmr_match = 1'b0;
        repeat (2) @(negedge clk);
        check(nedges == 16, {tag, " R2 edge count"}, nedges, 16);
        check(bad_iv == 0, {tag, " R2/R3/R4 edge spacing"}, bad_iv, 0);
        check(cap == tx, {tag, " R2 sdo byte"}, cap, tx);
        rd(AD, v);
        check(v == rxpat, {tag, " R7 buffer"}, v, rxpat);
        rd(AS, v);
        check(v[0] == 1'b1, {tag, " R7 full bit"}, v, 1);
    endtask

    // Slave exchange; the bench plays the remote master
    task automatic slave_xfer(input bit gated, input bit cpol, input logic [7:0] tx,
                              input logic [7:0] rxpat, input bit ss_lvl,
                              output logic [7:0] cap);
        cap = 8'd0;
        wr(AC, cw(1'b0, cpol, 4'b0101));
        sck_i = cpol; ss_i = 1'b1;
        repeat (6) @(negedge clk);
        wr(AC, cw(1'b1, cpol, gated ? 4'b0100 : 4'b0101));
        wr(AD, tx);
        ss_i = ss_lvl; sdi_i = rxpat[7];
        repeat (6) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            cap = {cap[6:0], sdo_o};
            sck_i = ~cpol;
            repeat (6) @(negedge clk);
            sck_i = cpol;
            repeat (2) @(negedge clk);
            if (i < 7) sdi_i = rxpat[6 - i];
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v, cap, a, b, tx, rxp;
        int unsigned seed_sink;
        seed_sink = $urandom(32'd2718);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(AC, v); check(v == 8'h00, "R1 control", v, 0);
        rd(AS, v); check(v == 8'h00, "R1 status", v, 0);
        rd(AD, v); check(v == 8'h00, "R1 data", v, 0);
        check(!sck_oe && !sdo_oe, "R1 enables", {sck_oe, sdo_oe}, 0);

        // R12 disabled and unsupported codes stay idle
        wr(AC, cw(1'b0, 1'b0, 4'b0000));
        wr(AD, 8'hA5);
        repeat (10) @(negedge clk);
        rd(AS, v); check(v == 8'h00, "R12 disabled no transfer", v, 0);
        check(!sck_oe && !sdo_oe, "R12 disabled pins", {sck_oe, sdo_oe}, 0);
        wr(AC, cw(1'b1, 1'b0, 4'b1001));
        wr(AD, 8'h3C);
        repeat (10) @(negedge clk);
        rd(AS, v); check(v == 8'h00, "R12 reserved code idle", v, 0);
        check(!sck_oe && !sdo_oe, "R12 reserved pins", {sck_oe, sdo_oe}, 0);
        wr(AC, cw(1'b1, 1'b0, 4'b0110));
        wr(AD, 8'h3C);
        repeat (10) @(negedge clk);
        rd(AC, v); check(v[7:6] == 2'b00, "R12 no flag from idle write", v, 0);
        rd(AD, v); check(v == 8'h00, "R12 buffer untouched", v, 0);

        // R2 directed master rates, R5 both idle levels
        master_xfer(4'b0000, 8'd0, 1'b0, 8'hA5, 8'h3C, -1, "q4");
        pop(v);
        rd(AS, v); check(v[0] == 1'b0, "R7 read clears full", v, 0);
        master_xfer(4'b0001, 8'd0, 1'b1, 8'h81, 8'h7E, -1, "q16");
        pop(v);
        master_xfer(4'b0010, 8'd0, 1'b0, 8'h01, 8'hFE, -1, "q64");
        pop(v);
        // R3 timer source
        master_xfer(4'b0011, 8'd0, 1'b1, 8'hC3, 8'h5A, -1, "tmr");
        pop(v);
        // R4 programmable divider, largest edge spacing used here
        master_xfer(4'b1010, 8'd9, 1'b0, 8'h96, 8'h69, -1, "prog");
        pop(v);

        // R9 master overwrite without overflow
        master_xfer(4'b0000, 8'd0, 1'b0, 8'h11, 8'h22, -1, "R9a");
        master_xfer(4'b0000, 8'd0, 1'b0, 8'h33, 8'h44, -1, "R9b");
        rd(AC, v); check(v[7] == 1'b0, "R9 no overflow in master", v[7], 0);
        rd(AD, v); check(v == 8'h44, "R9 newest byte kept", v, 8'h44);
        pop(v);

        // R10 write collision, byte in flight unaffected
        master_xfer(4'b0010, 8'd0, 1'b0, 8'hB7, 8'h4D, 20, "R10");
        rd(AC, v); check(v[6] == 1'b1, "R10 collision flag", v[6], 1);
        pop(v);
        // R11 writing 1 keeps, writing 0 clears
        wr(AC, cw(1'b1, 1'b0, 4'b0010));
        rd(AC, v); check(v[6] == 1'b1, "R11 write 1 keeps collision", v[6], 1);
        wr(AC, 8'b1000_1001);
        rd(AC, v); check(v[6] == 1'b0, "R11 write 0 clears collision", v[6], 0);

        // R6 gated slave with select high ignores the clock
        slave_xfer(1'b1, 1'b0, 8'h5A, 8'hC9, 1'b1, cap);
        rd(AS, v); check(v == 8'h00, "R6 ignored while deselected", v, 0);
        check(!sdo_oe && !sck_oe, "R6 pins released when deselected", {sck_oe, sdo_oe}, 0);
        // R6 gated slave selected
        slave_xfer(1'b1, 1'b1, 8'h5A, 8'hC9, 1'b0, cap);
        check(cap == 8'h5A, "R6 gated slave sdo", cap, 8'h5A);
        check(!sck_oe, "R6 slave never drives SCK", sck_oe, 0);
        pop(v); check(v == 8'hC9, "R6 gated slave rx", v, 8'hC9);
        // R6 ungated slave works with select high
        slave_xfer(1'b0, 1'b0, 8'h0F, 8'hE1, 1'b1, cap);
        check(cap == 8'h0F, "R6 ungated slave sdo", cap, 8'h0F);
        check(sdo_oe, "R6 ungated slave drives sdo", sdo_oe, 1);
        rd(AD, v); check(v == 8'hE1, "R7 slave rx", v, 8'hE1);

        // R8 overflow: second byte lost, first kept
        slave_xfer(1'b0, 1'b1, 8'h00, 8'h77, 1'b1, cap);
        rd(AC, v); check(v[7] == 1'b1, "R8 overflow flag", v[7], 1);
        rd(AD, v); check(v == 8'hE1, "R8 old byte kept", v, 8'hE1);
        pop(v);
        rd(AC, v); check(v[7] == 1'b1, "R11 overflow survives read", v[7], 1);
        wr(AC, 8'b0100_0101);
        rd(AC, v); check(v[7] == 1'b0, "R11 write 0 clears overflow", v[7], 0);

        // random master exchanges
        for (int k = 0; k < 24; k++) begin
            logic [3:0] m;
            logic [7:0] d;
            int r = $urandom % 4;
            m = (r == 0) ? 4'b0000 : (r == 1) ? 4'b0001 : (r == 2) ? 4'b0010 : 4'b1010;
            d = 8'($urandom % 6 + 1);
            tx = 8'($urandom); rxp = 8'($urandom);
            master_xfer(m, d, 1'($urandom), tx, rxp, -1, "rand master");
            pop(v);
            rd(AS, v); check(v[0] == 1'b0, "R7 rand read clears", v, 0);
        end
        // random slave exchanges
        for (int k = 0; k < 8; k++) begin
            tx = 8'($urandom); rxp = 8'($urandom);
            slave_xfer(1'($urandom), 1'($urandom), tx, rxp, 1'b0, cap);
            check(cap == tx, "R6 rand slave sdo", cap, tx);
            pop(v);
            check(v == rxp, "R7 rand slave rx", v, rxp);
        end
        a = 8'd0; b = a;
        rd(AC, v); check(v[7:6] == 2'b00, "R8/R10 no stray flags", v, b);

        summary();
        $finish;
    end
endmodule